// File: doc/BRIEF.md
# Serial Port Line Status Logic

This block holds the status flags of a serial port that has no receive or transmit queue. It watches the receiver (a pulse for each finished character, with qualifier flags for parity mismatch, missing stop bit and break) and the transmitter (a pulse when the holding register hands its byte to the shift register, and a level for an empty shift register). It combines these with the CPU's strobes: reading the receive buffer, reading the status word and writing the transmit holding register. From them it keeps an 8-bit status word that the CPU can read.

Three interrupt requests leave the block: data available, line error and transmit holding empty. Each is its status condition ANDed with its own enable input. Prioritising these requests, shifting the serial data and generating the baud clock happen elsewhere. The receiver checks only the first stop bit when it decides on a framing fault, so the frame flag arriving here never depends on the configured stop-bit count.

All flags are registered. A strobe seen at a rising edge shows in the status word immediately after that edge.

Top module: `line_status_unit`

## Requirements
- R1: While reset is active and right after it, the status word reads 0x60: bit 5 and bit 6 are 1 and every other bit is 0.
- R2: Bit 0 (data ready) becomes 1 after a cycle with `rxCharDone` high. It becomes 0 after a cycle with `cpuRdRxBuf` high and `rxCharDone` low. When both are high in the same cycle, it stays 1. Otherwise it holds its value.
- R3: Bit 1 (overrun) becomes 1 after a cycle in which `rxCharDone` is high, bit 0 is already 1 and `cpuRdRxBuf` is low. A read in that same cycle prevents it.
- R4: Bits 2, 3 and 4 take `rxParityErr`, `rxFrameErr` and `rxBreak` respectively, but only in a cycle with `rxCharDone` high. Without `rxCharDone` these flags have no effect, and a new 1 never clears a bit that is already set.
- R5: A cycle with `cpuRdStatus` high clears bits 1 to 4 after that edge. If one of those bits is set again in the same cycle, the set wins.
- R6: Bit 5 (holding register empty) becomes 1 after `txHoldToShift` and 0 after `cpuWrTxHold`. When both happen in the same cycle, the write wins and the bit becomes 0.
- R7: Bit 6 (transmitter idle) becomes 1 after a cycle only if bit 5 is 1 after that same edge and `txShiftEmpty` was high. Otherwise it becomes 0.
- R8: Bit 7 always reads 0.
- R9: `irqRxAvail` equals `enRxAvail` AND bit 0.
- R10: `irqLineErr` equals `enLineErr` AND (the OR of bits 1 to 4).
- R11: `irqTxEmpty` equals `enTxEmpty` AND bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxCharDone | input | 1 | Pulse: receiver finished a character into the buffer |
| rxParityErr | input | 1 | Parity mismatch on the finished character |
| rxFrameErr | input | 1 | First stop bit read as space |
| rxBreak | input | 1 | Line held at space for longer than a whole frame |
| txHoldToShift | input | 1 | Pulse: holding register moved its byte to the shift register |
| txShiftEmpty | input | 1 | Shift register holds no data |
| cpuRdRxBuf | input | 1 | CPU read strobe for the receive buffer |
| cpuRdStatus | input | 1 | CPU read strobe for the status word |
| cpuWrTxHold | input | 1 | CPU write strobe for the transmit holding register |
| enRxAvail | input | 1 | Enable for the data-available request |
| enLineErr | input | 1 | Enable for the line-error request |
| enTxEmpty | input | 1 | Enable for the holding-empty request |
| statusWord | output | 8 | Line status word |
| irqRxAvail | output | 1 | Data-available interrupt request |
| irqLineErr | output | 1 | Line-error interrupt request |
| irqTxEmpty | output | 1 | Holding-empty interrupt request |

## Verification
Two kinds of event can land in the same cycle here. A character can complete while the CPU reads the buffer or the status word. A CPU write to the holding register can coincide with the hand-off to the shift register. The stimulus table drives each of these pairs in a single cycle: a finished character together with a buffer read, a parity-flagged character together with a status read, and a write together with a transfer. It then compares the status word and the requests right after that edge. The expected values follow the stated precedences: a set beats a clear for the receive flags, and the write beats the transfer for bit 5.

// File: rtl/line_status_pkg.sv
package line_status_pkg;

  // Field positions in the status word; software decodes these.
  localparam int unsigned STATUS_W  = 8;
  localparam int unsigned ERR_FLAGS = 3;   // parity, frame, break
  localparam int unsigned POS_READY   = 0;
  localparam int unsigned POS_OVERRUN = 1;
  localparam int unsigned POS_ERR_LO  = 2;
  localparam int unsigned POS_HOLD    = POS_ERR_LO + ERR_FLAGS;  // 5
  localparam int unsigned POS_IDLE    = POS_HOLD + 1;            // 6
  localparam int unsigned POS_SPARE   = POS_IDLE + 1;            // 7

  // Strobes from control to datapath
  typedef struct packed {
    logic                 setReady;
    logic                 clrReady;
    logic                 setOverrun;
    logic [ERR_FLAGS-1:0] setErr;
    logic                 clrErr;
    logic                 setHoldEmpty;
    logic                 clrHoldEmpty;
    logic                 shiftIdle;
  } ctrlStrobes_t;

endpackage

// File: rtl/line_status_ctrl.sv
module line_status_ctrl
  import line_status_pkg::*;
(
  input  logic         rxCharDone,
  input  logic         rxParityErr,
  input  logic         rxFrameErr,
  input  logic         rxBreak,
  input  logic         txHoldToShift,
  input  logic         txShiftEmpty,
  input  logic         cpuRdRxBuf,
  input  logic         cpuRdStatus,
  input  logic         cpuWrTxHold,
  input  logic         readyNow,
  output ctrlStrobes_t strobes
);

  logic [ERR_FLAGS-1:0] rawErr;
  assign rawErr = {rxBreak, rxFrameErr, rxParityErr};

  always_comb begin
    strobes              = '0;
    strobes.setReady     = rxCharDone;
    strobes.clrReady     = cpuRdRxBuf;
    // A second character lands while the first is still unread
    strobes.setOverrun   = rxCharDone & readyNow & ~cpuRdRxBuf;
    strobes.setErr       = rxCharDone ? rawErr : '0;
    strobes.clrErr       = cpuRdStatus;
    strobes.setHoldEmpty = txHoldToShift;
    strobes.clrHoldEmpty = cpuWrTxHold;
    strobes.shiftIdle    = txShiftEmpty;
  end

endmodule

// File: rtl/line_status_dp.sv
module line_status_dp
  import line_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic                enRxAvail,
  input  logic                enLineErr,
  input  logic                enTxEmpty,
  output logic                readyNow,
  output logic [STATUS_W-1:0] statusWord,
  output logic                irqRxAvail,
  output logic                irqLineErr,
  output logic                irqTxEmpty
);

  logic                 readyQ;
  logic                 overrunQ;
  logic [ERR_FLAGS-1:0] errQ;
  logic                 holdEmptyQ;
  logic                 idleQ;
  logic                 holdEmptyNext;

  // Set has precedence over clear for the receive side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= 1'b0;
    end else if (strobes.setReady) begin
      readyQ <= 1'b1;
    end else if (strobes.clrReady) begin
      readyQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrunQ <= 1'b0;
    end else if (strobes.setOverrun) begin
      overrunQ <= 1'b1;
    end else if (strobes.clrErr) begin
      overrunQ <= 1'b0;
    end
  end

  for (genvar g = 0; g < ERR_FLAGS; g++) begin : gErrBit
    always_ff @(posedge clk) begin
      if (!rstN) begin
        errQ[g] <= 1'b0;
      end else if (strobes.setErr[g]) begin
        errQ[g] <= 1'b1;
      end else if (strobes.clrErr) begin
        errQ[g] <= 1'b0;
      end
    end
  end

  // A write refills the holding register, so the write has precedence
  always_comb begin
    holdEmptyNext = holdEmptyQ;
    if (strobes.clrHoldEmpty) begin
      holdEmptyNext = 1'b0;
    end else if (strobes.setHoldEmpty) begin
      holdEmptyNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdEmptyQ <= 1'b1;
      idleQ      <= 1'b1;
    end else begin
      holdEmptyQ <= holdEmptyNext;
      idleQ      <= holdEmptyNext & strobes.shiftIdle;
    end
  end

  always_comb begin
    statusWord                                = '0;
    statusWord[POS_READY]                     = readyQ;
    statusWord[POS_OVERRUN]                   = overrunQ;
    statusWord[POS_ERR_LO +: ERR_FLAGS]       = errQ;
    statusWord[POS_HOLD]                      = holdEmptyQ;
    statusWord[POS_IDLE]                      = idleQ;
    statusWord[POS_SPARE]                     = 1'b0;
  end

  assign readyNow   = readyQ;
  assign irqRxAvail = enRxAvail & readyQ;
  assign irqLineErr = enLineErr & (overrunQ | (|errQ));
  assign irqTxEmpty = enTxEmpty & holdEmptyQ;

endmodule

// File: rtl/line_status_unit.sv
module line_status_unit
  import line_status_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxCharDone,
  input  logic       rxParityErr,
  input  logic       rxFrameErr,
  input  logic       rxBreak,
  input  logic       txHoldToShift,
  input  logic       txShiftEmpty,
  input  logic       cpuRdRxBuf,
  input  logic       cpuRdStatus,
  input  logic       cpuWrTxHold,
  input  logic       enRxAvail,
  input  logic       enLineErr,
  input  logic       enTxEmpty,
  output logic [7:0] statusWord,
  output logic       irqRxAvail,
  output logic       irqLineErr,
  output logic       irqTxEmpty
);

  ctrlStrobes_t strobes;
  logic         readyNow;

  line_status_ctrl i_ctrl (
    .rxCharDone    (rxCharDone),
    .rxParityErr   (rxParityErr),
    .rxFrameErr    (rxFrameErr),
    .rxBreak       (rxBreak),
    .txHoldToShift (txHoldToShift),
    .txShiftEmpty  (txShiftEmpty),
    .cpuRdRxBuf    (cpuRdRxBuf),
    .cpuRdStatus   (cpuRdStatus),
    .cpuWrTxHold   (cpuWrTxHold),
    .readyNow      (readyNow),
    .strobes       (strobes)
  );

  line_status_dp i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .enRxAvail  (enRxAvail),
    .enLineErr  (enLineErr),
    .enTxEmpty  (enTxEmpty),
    .readyNow   (readyNow),
    .statusWord (statusWord),
    .irqRxAvail (irqRxAvail),
    .irqLineErr (irqLineErr),
    .irqTxEmpty (irqTxEmpty)
  );

endmodule

// File: rtl/line_status_checker.sv
module line_status_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rxCharDone,
  input logic       txHoldToShift,
  input logic       txShiftEmpty,
  input logic       cpuRdRxBuf,
  input logic       cpuRdStatus,
  input logic       cpuWrTxHold,
  input logic [7:0] statusWord,
  input logic       irqLineErr
);

  assert_ready_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxCharDone |=> statusWord[0]);

  assert_ready_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdRxBuf && !rxCharDone) |=> !statusWord[0]);

  assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxCharDone && statusWord[0] && !cpuRdRxBuf) |=> statusWord[1]);

  assert_errors_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdStatus && !rxCharDone) |=> (statusWord[4:1] == 4'b0000));

  assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrTxHold |=> !statusWord[5]);

  assert_transfer_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txHoldToShift && !cpuWrTxHold) |=> statusWord[5]);

  assert_idle_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txHoldToShift && !cpuWrTxHold && txShiftEmpty) |=> statusWord[6]);

  assert_spare_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[7]);

  assert_line_irq_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqLineErr |-> (statusWord[4:1] != 4'b0000));

endmodule

bind line_status_unit line_status_checker i_checker (
  .clk           (clk),
  .rstN          (rstN),
  .rxCharDone    (rxCharDone),
  .txHoldToShift (txHoldToShift),
  .txShiftEmpty  (txShiftEmpty),
  .cpuRdRxBuf    (cpuRdRxBuf),
  .cpuRdStatus   (cpuRdStatus),
  .cpuWrTxHold   (cpuWrTxHold),
  .statusWord    (statusWord),
  .irqLineErr    (irqLineErr)
);

// File: tb/test_line_status_unit.sv
module test_line_status_unit;

  logic       clk = 1'b0;
  logic       rstN;
  logic       rxCharDone, rxParityErr, rxFrameErr, rxBreak;
  logic       txHoldToShift, txShiftEmpty;
  logic       cpuRdRxBuf, cpuRdStatus, cpuWrTxHold;
  logic       enRxAvail, enLineErr, enTxEmpty;
  logic [7:0] statusWord;
  logic       irqRxAvail, irqLineErr, irqTxEmpty;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  line_status_unit i_line_status_unit (
    .clk(clk), .rstN(rstN),
    .rxCharDone(rxCharDone), .rxParityErr(rxParityErr),
    .rxFrameErr(rxFrameErr), .rxBreak(rxBreak),
    .txHoldToShift(txHoldToShift), .txShiftEmpty(txShiftEmpty),
    .cpuRdRxBuf(cpuRdRxBuf), .cpuRdStatus(cpuRdStatus),
    .cpuWrTxHold(cpuWrTxHold),
    .enRxAvail(enRxAvail), .enLineErr(enLineErr), .enTxEmpty(enTxEmpty),
    .statusWord(statusWord),
    .irqRxAvail(irqRxAvail), .irqLineErr(irqLineErr), .irqTxEmpty(irqTxEmpty)
  );

  // Stimulus: [11:9] enables rx/line/tx, [8] write hold, [7] status read,
  // [6] buffer read, [5] shift empty, [4] hold->shift, [3] break,
  // [2] frame, [1] parity, [0] char done
  localparam int NVEC = 15;
  localparam logic [11:0] STIM [NVEC] = '{
    12'b111_000_10_0000,  // idle                          R1
    12'b111_100_10_0000,  // write holding                 R6 R7
    12'b111_000_01_0000,  // transfer, shift busy          R6 R7
    12'b111_000_00_0000,  // shift busy                    R7
    12'b111_000_10_0000,  // shift empties                 R7
    12'b111_000_10_0001,  // clean char                    R2 R9
    12'b111_000_10_0011,  // char with parity, unread      R3 R4 R10
    12'b111_010_10_0000,  // status read                   R5
    12'b111_001_10_0101,  // framed char + buffer read     R2 R3 R4
    12'b111_011_10_0000,  // buffer + status read          R2 R5
    12'b000_000_10_1101,  // break+frame, enables off      R4 R9 R10 R11
    12'b010_010_10_0011,  // status read + parity char     R3 R5
    12'b111_111_11_0000,  // write + transfer + reads      R6 R2 R5
    12'b111_000_11_0000,  // transfer alone                R6 R7
    12'b111_000_10_1110   // flags without char done       R4
  };
  // Expected: [10:8] irq rx/line/tx, [7:0] status word
  localparam logic [10:0] EXPECT [NVEC] = '{
    11'b001_0110_0000,
    11'b000_0000_0000,
    11'b001_0010_0000,
    11'b001_0010_0000,
    11'b001_0110_0000,
    11'b101_0110_0001,
    11'b111_0110_0111,
    11'b101_0110_0001,
    11'b111_0110_1001,
    11'b001_0110_0000,
    11'b000_0111_1001,
    11'b010_0110_0111,
    11'b000_0000_0000,
    11'b001_0110_0000,
    11'b001_0110_0000
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [11:0] v);
    {enRxAvail, enLineErr, enTxEmpty, cpuWrTxHold, cpuRdStatus, cpuRdRxBuf,
     txShiftEmpty, txHoldToShift, rxBreak, rxFrameErr, rxParityErr, rxCharDone} = v;
  endtask

  initial begin
    rstN = 1'b0;
    drive(12'b111_000_10_0000);
    repeat (3) @(posedge clk);
    #1;
    check("R1 status during reset", statusWord, 8'h60);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 status after reset", statusWord, 8'h60);
    check("R11 tx irq after reset", irqTxEmpty, 1'b1);
    check("R9 R10 rx/line irq after reset", {irqRxAvail, irqLineErr}, 2'b00);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(STIM[i]);
      @(posedge clk); #1;
      check($sformatf("R2-R7 status vector %0d", i), statusWord, EXPECT[i][7:0]);
      check($sformatf("R9 R10 R11 irqs vector %0d", i),
            {irqRxAvail, irqLineErr, irqTxEmpty}, EXPECT[i][10:8]);
      check($sformatf("R8 spare bit vector %0d", i), statusWord[7], 1'b0);
    end

    // Directed: overrun prevented by a read in the same cycle (R3)
    @(negedge clk); drive(12'b111_000_10_0001);  // ready = 1
    @(negedge clk); drive(12'b111_001_10_0001);  // char + read
    @(posedge clk); #1;
    check("R3 no overrun with same-cycle read", statusWord[1], 1'b0);
    check("R2 ready kept when char and read coincide", statusWord[0], 1'b1);

    // Directed: reset mid-run restores the idle word (R1)
    @(negedge clk); drive(12'b111_100_10_0011);
    @(negedge clk); drive(12'b111_000_10_0000); rstN = 1'b0;
    @(posedge clk); #1;
    check("R1 reset mid-run", statusWord, 8'h60);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 word held after reset release", statusWord, 8'h60);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

endmodule